// File: doc/BRIEF.md
# Indirect Register Window Port

This block is a small bank of 8-byte registers on a simple request bus with a valid/ready handshake. It opens a window onto a separate 4 KB internal register space: software first loads a pointer register with a 12-bit internal address. Each access to the window register is then carried across to an internal target at that address. Reading the window returns the target's 64-bit read data. Writing the window sends the bus data to the target, and the bank keeps no copy of it.

Alongside the pointer and the window there is a sticky status register. Hardware sets bit 0 when the target answers with an error, and software clears any bit by writing a one to it. Two control slots accept writes and throw them away quietly. Writes to any other slot are refused with an error pulse. The bus master holds its request (valid, address, write flag, data) until ready is seen high. Window accesses hold ready low until the target answers.

Top module: `ipt_port`

## Requirements
- R1: After a synchronous active-low reset the pointer and status registers read 0, no target request is pending, and ready is high for any non-window slot.
- R2: The register slot is the bus byte address shifted right by 3; the three lowest address bits have no effect. Slots: 0 pointer, 1 status, 2 window, 3 and 4 discard slots, 5 to 7 unassigned.
- R3: A write to the pointer keeps only bits 11:0; reading it returns them zero-extended to 64 bits.
- R4: A write to status clears each status bit whose data bit is 1 and leaves every other status bit unchanged.
- R5: A target response with its error flag high sets status bit 0, which then stays set until cleared by R4.
- R6: A window write issues one target write at the pointer's address with the full 64-bit bus data; the bank's own registers are unchanged by it.
- R7: A window read issues one target read at the pointer's address and returns the target's data on the bus in the cycle the target acknowledges.
- R8: Writes to the discard slots complete without error and change no state; reads of them return 0.
- R9: A write to an unassigned slot completes with the error output high for that one transfer and changes no state; reads of unassigned slots return 0 without error.
- R10: During a window access the target request and address stay steady and bus ready stays low until the target acknowledges; with a target latency of L cycles the bus access takes L+2 cycles from valid to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Bus request valid, held until ready |
| bus_ready | output | 1 | Transfer completes when valid and ready are both high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | IDX_W+3 | Byte address; slot = address >> 3 |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the completing cycle |
| bus_err | output | 1 | Refused write, high in the completing cycle |
| tgt_req | output | 1 | Internal target request, held until acknowledge |
| tgt_we | output | 1 | Internal target write flag |
| tgt_addr | output | TADDR_W | Internal target address |
| tgt_wdata | output | DATA_W | Internal target write data |
| tgt_ack | input | 1 | Target acknowledge, one cycle |
| tgt_rdata | input | DATA_W | Target read data, valid with acknowledge |
| tgt_err | input | 1 | Target error flag, valid with acknowledge |

## Verification
The window path is exercised with target latencies of 0, 1, 2 and 3 cycles, so the stall count shows whether ready tracks the acknowledge or some fixed delay. Reads and writes go to the window at two pointer values, one of which makes the target report an error, so a wrong address, lost write data or a missed sticky error shows up as a mismatch. Status clears are tried with all-zero data, with every bit except bit 0, and with bit 0 alone, which tells clearing by mask apart from clearing the whole register. Discard-slot and unassigned-slot writes are followed by reads of pointer and status, so a write that leaks into state is caught as well as a wrong error flag.

// File: rtl/ipt_pkg.sv
// Shared constants and types for the indirect register window port.
// Assumes an 8-byte-wide bus where the slot number is the byte address >> 3.
package ipt_pkg;
    localparam int IDX_W   = 3;
    localparam int DATA_W  = 64;
    localparam int TADDR_W = 12;
    localparam int STAT_W  = 8;

    localparam logic [IDX_W-1:0] IX_PTR   = 3'd0;
    localparam logic [IDX_W-1:0] IX_STAT  = 3'd1;
    localparam logic [IDX_W-1:0] IX_WIN   = 3'd2;
    localparam logic [IDX_W-1:0] IX_DROPA = 3'd3;
    localparam logic [IDX_W-1:0] IX_DROPB = 3'd4;

    typedef enum logic {SQ_IDLE, SQ_WAIT} seq_state_t;

    typedef struct packed {
        logic ptr;
        logic stat;
        logic win;
        logic drop;
        logic none;
    } slot_hit_t;
endpackage

// File: rtl/ipt_decode.sv
// Slot decoder: turns the slot number into one-hot hit flags.
// Assumes the caller has already removed the three byte-offset bits.
module ipt_decode
    import ipt_pkg::*;
(
    input  logic [IDX_W-1:0] slot,
    output slot_hit_t        hit
);
    // Classify the slot into pointer, status, window, discard or unassigned.
    always_comb begin
        hit = '0;
        unique case (slot)
            IX_PTR:             hit.ptr  = 1'b1;
            IX_STAT:            hit.stat = 1'b1;
            IX_WIN:             hit.win  = 1'b1;
            IX_DROPA, IX_DROPB: hit.drop = 1'b1;
            default:            hit.none = 1'b1;
        endcase
    end
endmodule

// File: rtl/ipt_regs.sv
// Local state: the 12-bit pointer and the sticky status register.
// Assumes wr_en is only high for an accepted local write; status bit 0
// may also be set by hardware, and the set wins over a clear.
module ipt_regs #(
    parameter int TADDR_W = 12,
    parameter int STAT_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ptr,
    input  logic               wr_stat,
    input  logic [TADDR_W-1:0] ptr_wd,
    input  logic [STAT_W-1:0]  stat_wd,
    input  logic               hw_err,
    output logic [TADDR_W-1:0] ptr_q,
    output logic [STAT_W-1:0]  stat_q
);
    // Pointer register: loads the low address bits on a pointer write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (wr_ptr) ptr_q <= ptr_wd;
    end

    // One flop per status bit; bit 0 also takes the hardware error event.
    for (genvar b = 0; b < STAT_W; b++) begin : g_stat
        logic set_b;
        if (b == 0) begin : g_hw
            assign set_b = hw_err;
        end else begin : g_sw
            assign set_b = 1'b0;
        end
        // Sticky bit: set by hardware, cleared by a one written to it.
        always_ff @(posedge clk) begin
            if (!rst_n)                   stat_q[b] <= 1'b0;
            else if (set_b)               stat_q[b] <= 1'b1;
            else if (wr_stat && stat_wd[b]) stat_q[b] <= 1'b0;
        end
    end
endmodule

// File: rtl/ipt_seq.sv
// Window sequencer: launches one target access per window transfer and
// holds the request until the target acknowledges.
// Assumes start is only high while idle.
module ipt_seq
    import ipt_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              we_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic              ack,
    output logic              busy,
    output logic              req_we,
    output logic [DATA_W-1:0] req_wdata
);
    seq_state_t state_q;

    // State machine: idle until a window access, wait until acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            unique case (state_q)
                SQ_IDLE: if (start) state_q <= SQ_WAIT;
                SQ_WAIT: if (ack)   state_q <= SQ_IDLE;
                default:            state_q <= SQ_IDLE;
            endcase
        end
    end

    // Capture the direction and write data when the access is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_we    <= 1'b0;
            req_wdata <= '0;
        end else if (start) begin
            req_we    <= we_in;
            req_wdata <= wdata_in;
        end
    end

    assign busy = (state_q == SQ_WAIT);
endmodule

// File: rtl/ipt_port.sv
// Indirect register window port (top). Local pointer/status registers,
// two discard slots and a window slot forwarded to an internal target.
// Assumes the bus master holds valid, address, direction and data until
// ready; transfers complete in the cycle where valid and ready are high.
module ipt_port
    import ipt_pkg::*;
#(
    parameter int DATA_W  = ipt_pkg::DATA_W,
    parameter int TADDR_W = ipt_pkg::TADDR_W,
    parameter int STAT_W  = ipt_pkg::STAT_W,
    localparam int BUS_AW = IDX_W + 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    output logic               bus_ready,
    input  logic               bus_we,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err,
    output logic               tgt_req,
    output logic               tgt_we,
    output logic [TADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0]  tgt_wdata,
    input  logic               tgt_ack,
    input  logic [DATA_W-1:0]  tgt_rdata,
    input  logic               tgt_err
);
    slot_hit_t          hit;
    logic               busy;
    logic               accept;
    logic               local_wr;
    logic [TADDR_W-1:0] ptr_q;
    logic [STAT_W-1:0]  stat_q;
    logic               unused_lsb;

    assign unused_lsb = ^bus_addr[2:0];

    ipt_decode u_dec (
        .slot (bus_addr[BUS_AW-1:3]),
        .hit  (hit)
    );

    // Handshake: window transfers wait for the target, others finish at once.
    assign bus_ready = busy ? tgt_ack : ~hit.win;
    assign accept    = bus_valid & bus_ready;
    assign local_wr  = accept & bus_we & ~busy;
    assign bus_err   = local_wr & hit.none;

    ipt_regs #(.TADDR_W(TADDR_W), .STAT_W(STAT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ptr  (local_wr & hit.ptr),
        .wr_stat (local_wr & hit.stat),
        .ptr_wd  (bus_wdata[TADDR_W-1:0]),
        .stat_wd (bus_wdata[STAT_W-1:0]),
        .hw_err  (busy & tgt_ack & tgt_err),
        .ptr_q   (ptr_q),
        .stat_q  (stat_q)
    );

    ipt_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (bus_valid & ~busy & hit.win),
        .we_in     (bus_we),
        .wdata_in  (bus_wdata),
        .ack       (tgt_ack),
        .busy      (busy),
        .req_we    (tgt_we),
        .req_wdata (tgt_wdata)
    );

    assign tgt_req  = busy;
    assign tgt_addr = ptr_q;

    // Read mux: target data while waiting, local registers otherwise.
    always_comb begin
        bus_rdata = '0;
        if (busy)          bus_rdata = tgt_rdata;
        else if (hit.ptr)  bus_rdata[TADDR_W-1:0] = ptr_q;
        else if (hit.stat) bus_rdata[STAT_W-1:0]  = stat_q;
    end
endmodule

// File: rtl/ipt_port_chk.sv
// Property checker for ipt_port, attached with bind. Observes ports and
// the status register; drives nothing.
module ipt_port_chk
    import ipt_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int TADDR_W = 12,
    parameter int STAT_W  = 8,
    localparam int BUS_AW = IDX_W + 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_valid,
    input logic               bus_ready,
    input logic               bus_we,
    input logic [BUS_AW-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               bus_err,
    input logic               tgt_req,
    input logic [TADDR_W-1:0] tgt_addr,
    input logic               tgt_ack,
    input logic               tgt_err,
    input logic [STAT_W-1:0]  stat_q
);
    logic [IDX_W-1:0] slot;
    logic             xfer;
    assign slot = bus_addr[BUS_AW-1:3];
    assign xfer = bus_valid & bus_ready;

    // R10: an unanswered request persists with a steady address.
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req && !tgt_ack |=> tgt_req && $stable(tgt_addr));

    // R10: while a request is out, ready follows the acknowledge only.
    p_ready_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req |-> (bus_ready == tgt_ack));

    // R3: pointer reads carry nothing above bit 11.
    p_ptr_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && !bus_we && !tgt_req && slot == IX_PTR
        |-> bus_rdata[DATA_W-1:TADDR_W] == '0);

    // R5: a target error leaves status bit 0 set.
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req && tgt_ack && tgt_err |=> stat_q[0]);

    // R4: a status write clears exactly the bits written as one.
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && bus_we && !tgt_req && slot == IX_STAT
        |=> stat_q == ($past(stat_q) & ~$past(bus_wdata[STAT_W-1:0])));

    // R9: the error output only appears on a completing write.
    p_err_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> xfer && bus_we);

    // R8: discard slots never report an error.
    p_drop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && (slot == IX_DROPA || slot == IX_DROPB) |-> !bus_err);
endmodule

bind ipt_port ipt_port_chk #(
    .DATA_W(DATA_W), .TADDR_W(TADDR_W), .STAT_W(STAT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .tgt_req   (tgt_req),
    .tgt_addr  (tgt_addr),
    .tgt_ack   (tgt_ack),
    .tgt_err   (tgt_err),
    .stat_q    (stat_q)
);

// File: tb/ipt_port_tb.sv
// Scoreboard bench: the access task queues expected results, a monitor
// compares them when transfers complete, a target model answers requests.
module ipt_port_tb;
    import ipt_pkg::*;
    localparam int AW = IDX_W + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [63:0]   bus_wdata = '0;
    logic          bus_ready, bus_err;
    logic [63:0]   bus_rdata;
    logic          tgt_req, tgt_we;
    logic [11:0]   tgt_addr;
    logic [63:0]   tgt_wdata;
    logic          tgt_ack = 1'b0, tgt_err = 1'b0;
    logic [63:0]   tgt_rdata = '0;

    always #5 clk = ~clk;

    ipt_port u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .tgt_req(tgt_req), .tgt_we(tgt_we),
        .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_ack(tgt_ack),
        .tgt_rdata(tgt_rdata), .tgt_err(tgt_err)
    );

    typedef struct {
        logic [63:0] rd;
        bit          chk_rd;
        bit          err;
        string       req;
    } exp_t;

    exp_t        expq[$];
    int          n_chk = 0, n_err = 0;
    int          lat = 0, stall = 0, wr_cnt = 0;
    logic [11:0] wr_addr_seen = '0;
    logic [63:0] wr_data_seen = '0;

    function automatic logic [63:0] tmodel(input logic [11:0] a);
        return {a, 40'h5A5AC3C300, a};
    endfunction

    function automatic logic [AW-1:0] ba(input logic [IDX_W-1:0] s);
        return {s, 3'b000};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exv);
        end
    endtask

    // Driver: queue the expectation, present the request, hold until ready.
    task automatic access(input bit we, input logic [AW-1:0] a,
                          input logic [63:0] wd, input logic [63:0] erd,
                          input bit crd, input bit eerr, input string req);
        exp_t e;
        e.rd = erd; e.chk_rd = crd; e.err = eerr; e.req = req;
        expq.push_back(e);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        stall = 0;
        forever begin
            #4;
            if (bus_ready) break;
            stall++;
            @(negedge clk);
        end
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // Monitor: compare each completed transfer against the queue head.
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (rst_n && bus_valid && bus_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, "scoreboard-empty", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check(bus_err == e.err, {e.req, " err"},
                          {63'd0, bus_err}, {63'd0, e.err});
                    if (e.chk_rd)
                        check(bus_rdata == e.rd, {e.req, " rdata"},
                              bus_rdata, e.rd);
                end
            end
        end
    end

    // Target model: answers after lat cycles, logs writes.
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (tgt_ack) begin
                tgt_ack = 1'b0;
            end else if (tgt_req) begin
                if (cnt == lat) begin
                    cnt = 0;
                    tgt_ack   = 1'b1;
                    tgt_rdata = tmodel(tgt_addr);
                    tgt_err   = (tgt_addr == 12'hEEE);
                    if (tgt_we) begin
                        wr_addr_seen = tgt_addr;
                        wr_data_seen = tgt_wdata;
                        wr_cnt++;
                    end
                end else begin
                    cnt++;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 64'd1, 64'd0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #4;
        check(tgt_req == 1'b0, "R1 req idle", {63'd0, tgt_req}, 64'd0);
        check(bus_ready == 1'b1, "R1 ready", {63'd0, bus_ready}, 64'd1);
        access(0, ba(IX_PTR), 0, 64'd0, 1, 0, "R1 ptr reset");
        access(0, ba(IX_STAT), 0, 64'd0, 1, 0, "R1 stat reset");

        access(1, ba(IX_PTR), 64'hFFFF_FFFF_FFFF_F123, 0, 0, 0, "R3 ptr write");
        access(0, ba(IX_PTR), 0, 64'h123, 1, 0, "R3 ptr read");
        access(0, {IX_PTR, 3'b101}, 0, 64'h123, 1, 0, "R2 offset bits");
        access(0, {IX_STAT, 3'b111}, 0, 64'd0, 1, 0, "R2 offset bits stat");

        lat = 2;
        access(1, ba(IX_WIN), 64'h0123_4567_89AB_CDEF, 0, 0, 0, "R6 win write");
        check(stall == 3, "R10 stall lat2", stall, 3);
        check(wr_cnt == 1, "R6 one target write", wr_cnt, 1);
        check(wr_addr_seen == 12'h123, "R6 target addr", {52'd0, wr_addr_seen}, 64'h123);
        check(wr_data_seen == 64'h0123_4567_89AB_CDEF, "R6 target data",
              wr_data_seen, 64'h0123_4567_89AB_CDEF);
        access(0, ba(IX_PTR), 0, 64'h123, 1, 0, "R6 ptr kept");

        lat = 0;
        access(0, ba(IX_WIN), 0, tmodel(12'h123), 1, 0, "R7 win read lat0");
        check(stall == 1, "R10 stall lat0", stall, 1);
        lat = 3;
        access(0, ba(IX_WIN), 0, tmodel(12'h123), 1, 0, "R7 win read lat3");
        check(stall == 4, "R10 stall lat3", stall, 4);
        check(wr_cnt == 1, "R7 reads write nothing", wr_cnt, 1);
        access(0, ba(IX_STAT), 0, 64'd0, 1, 0, "R5 no error yet");

        access(1, ba(IX_PTR), 64'hEEE, 0, 0, 0, "R5 ptr to error addr");
        lat = 1;
        access(0, ba(IX_WIN), 0, tmodel(12'hEEE), 1, 0, "R7 win read err");
        check(stall == 2, "R10 stall lat1", stall, 2);
        access(0, ba(IX_STAT), 0, 64'd1, 1, 0, "R5 status set");

        access(1, ba(IX_STAT), 64'd0, 0, 0, 0, "R4 clear none");
        access(0, ba(IX_STAT), 0, 64'd1, 1, 0, "R4 kept after zero");
        access(1, ba(IX_STAT), ~64'd1, 0, 0, 0, "R4 clear others");
        access(0, ba(IX_STAT), 0, 64'd1, 1, 0, "R4 kept after mask");
        access(1, ba(IX_STAT), 64'd1, 0, 0, 0, "R4 clear bit0");
        access(0, ba(IX_STAT), 0, 64'd0, 1, 0, "R4 cleared");

        access(1, ba(IX_DROPA), '1, 0, 0, 0, "R8 discard A");
        access(1, ba(IX_DROPB), '1, 0, 0, 0, "R8 discard B");
        access(0, ba(IX_PTR), 0, 64'hEEE, 1, 0, "R8 ptr unchanged");
        access(0, ba(IX_STAT), 0, 64'd0, 1, 0, "R8 stat unchanged");
        access(0, ba(IX_DROPA), 0, 64'd0, 1, 0, "R8 discard read");

        access(1, ba(3'd7), '1, 0, 0, 1, "R9 slot7 refused");
        access(1, ba(3'd5), 64'd1, 0, 0, 1, "R9 slot5 refused");
        access(0, ba(3'd6), 0, 64'd0, 1, 0, "R9 slot6 read");
        access(0, ba(IX_PTR), 0, 64'hEEE, 1, 0, "R9 ptr unchanged");
        access(0, ba(IX_STAT), 0, 64'd0, 1, 0, "R9 stat unchanged");
        check(wr_cnt == 1, "R9 no target write", wr_cnt, 1);

        repeat (3) @(negedge clk);
        check(expq.size() == 0, "scoreboard drained", expq.size(), 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule